// File: doc/BRIEF.md
# Command Packet Framer

This block sits between a source of 32-bit drawing command words and a rendering pipeline. Words arrive one at a time over a valid/ready handshake. The framer groups them into whole command packets. The top byte of the first word in a packet is the opcode. The opcode either fixes the number of words in the packet or marks the packet as a polyline. A polyline runs until a terminator word appears, or until a length cap is reached.

When a packet is complete, it goes to one of three places:
- Drawing packets are replayed word by word on a renderer port. Each word carries its opcode, the packet length, first and last markers, and an overflow flag.
- Image-transfer headers are presented as a single beat on a transfer port. The beat carries a read/write flag, the position word and the size word.
- Environment-setting words are stored in an eight-entry register bank. They produce no packet.

A packet is never released until its last word has been taken. While a packet is being released, intake is stopped.

Top module: `cmd_packet_framer`

## Requirements
- R1: After reset `out_valid` and `xfer_valid` are 0 and `in_ready` is 1. Environment register k (bits 32k+31:32k of `env_regs`) holds opcode 0xE0+k in bits 31:24 and zero in bits 23:0.
- R2: Opcodes 0x20–0x3F form fixed packets whose total length depends on the opcode group. 0x20–23 give 4 words, 0x24–27 give 7, 0x28–2B give 5, 0x2C–2F give 9, 0x30–33 give 6, 0x34–37 give 9, 0x38–3B give 8 and 0x3C–3F give 12.
- R3: The following fixed packets have these total lengths. Opcode 0x02 gives 3 words, 0x40–0x47 give 3 and 0x50–0x57 give 5. Opcode 0x80 gives 4. In the 0x60–0x7F range, 0x60–63 give 3, 0x64–67 give 4, 0x68–6B give 2, 0x6C–6F give 1, 0x70–73 give 2, 0x74–77 give 3, 0x78–7B give 2 and 0x7C–7F give 3.
- R4: Any opcode not covered by R2, R3, R5, R6, R8 or R9 forms a one-word packet, released right after that word is taken.
- R5: For opcodes 0x48–0x4F, every word at index 3 or later (the first word is index 0) is tested. A word is a terminator when (word AND 0xF000F000) equals 0x50005000. The packet ends with the first terminator, and the terminator is included in the packet. A matching word at index 1 or 2 is treated as data.
- R6: For opcodes 0x58–0x5F, only words at even indices of 4 or more are tested with the terminator rule of R5. A matching word at an odd index is treated as data.
- R7: A polyline that reaches MAX_WORDS words without a terminator is closed at exactly MAX_WORDS words with `out_ovf` set. A terminator exactly at index MAX_WORDS-1 closes the packet at the same length with `out_ovf` clear.
- R8: A word with opcode 0xE0–0xE7 is written whole into environment register opcode[2:0]. Nothing appears on the renderer or transfer ports for it.
- R9: Opcodes 0xA0–0xDF form 3-word transfer headers. Each header is presented as one beat on the transfer port with `xfer_pos` = word 1 and `xfer_size` = word 2. `xfer_read` is 1 for 0xC0–0xDF and 0 for 0xA0–0xBF. Nothing appears on the renderer port for them.
- R10: While a packet still lacks words, `out_valid` and `xfer_valid` stay 0, however long the gap between words.
- R11: A packet is released in arrival order, one word per accepted beat. `out_first` marks word 0, `out_last` marks the final word, and `out_opcode`/`out_len` stay constant across the packet. While `out_ready` is 0 every output holds its value. While `out_valid` is 1, `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command word offered |
| in_ready | output | 1 | Framer accepts a word |
| in_word | input | 32 | Command word |
| out_valid | output | 1 | Renderer word valid |
| out_ready | input | 1 | Renderer takes the word |
| out_word | output | 32 | Packet word |
| out_first | output | 1 | Word 0 of the packet |
| out_last | output | 1 | Final word of the packet |
| out_opcode | output | 8 | Packet opcode |
| out_len | output | $clog2(MAX_WORDS+1) | Packet length in words |
| out_ovf | output | 1 | Polyline closed by the length cap |
| xfer_valid | output | 1 | Transfer header valid |
| xfer_ready | input | 1 | Transfer port takes the header |
| xfer_read | output | 1 | 1 = read from image memory, 0 = write |
| xfer_pos | output | 32 | Header position word |
| xfer_size | output | 32 | Header size word |
| env_regs | output | 256 | Eight environment registers, register k at bits 32k+31:32k |

## Verification
Two closing conditions can fall in the same cycle: the length cap of a polyline and its terminator test. The bench provokes this by placing a terminator exactly at the cap index for the all-words variant, and a matching pattern at the odd cap index for the alternate-word variant. The first must close without overflow and the second with overflow. A second coincidence is decoding and closing in one cycle. The bench sweeps every opcode, which covers all one-word packets, and compares each released packet against lengths computed from opcode ranges in the bench. A run with a randomly stalling `out_ready` checks that the outputs hold while stalled.

// File: rtl/cpf_pkg.sv
package cpf_pkg;

    localparam logic [31:0] TERM_MASK = 32'hF000_F000;
    localparam logic [31:0] TERM_VAL  = 32'h5000_5000;

    typedef enum logic [2:0] {
        K_FIXED,
        K_LINE_ALL,
        K_LINE_ALT,
        K_ENV,
        K_XFER
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [3:0] extra;
    } op_info_t;

    typedef enum logic [1:0] {
        ST_GATHER,
        ST_DRAW,
        ST_XFER
    } state_e;

    // parameter words for the 0x20..0x3F family, per group of four opcodes
    function automatic logic [3:0] poly_extra(input logic [2:0] grp);
        logic [3:0] r;
        case (grp)
            3'd0: r = 4'd3;
            3'd1: r = 4'd6;
            3'd2: r = 4'd4;
            3'd3: r = 4'd8;
            3'd4: r = 4'd5;
            3'd5: r = 4'd8;
            3'd6: r = 4'd7;
            default: r = 4'd11;
        endcase
        return r;
    endfunction

    // parameter words for the 0x60..0x7F family, per group of four opcodes
    function automatic logic [3:0] box_extra(input logic [2:0] grp);
        logic [3:0] r;
        case (grp)
            3'd0: r = 4'd2;
            3'd1: r = 4'd3;
            3'd2: r = 4'd1;
            3'd3: r = 4'd0;
            3'd4: r = 4'd1;
            3'd5: r = 4'd2;
            3'd6: r = 4'd1;
            default: r = 4'd2;
        endcase
        return r;
    endfunction

    function automatic op_info_t classify(input logic [7:0] op);
        op_info_t r;
        r.kind  = K_FIXED;
        r.extra = 4'd0;
        if (op == 8'h02) begin
            r.extra = 4'd2;
        end else if (op[7:5] == 3'b001) begin
            r.extra = poly_extra(op[4:2]);
        end else if (op[7:4] == 4'h4) begin
            if (op[3]) r.kind = K_LINE_ALL;
            else       r.extra = 4'd2;
        end else if (op[7:4] == 4'h5) begin
            if (op[3]) r.kind = K_LINE_ALT;
            else       r.extra = 4'd4;
        end else if (op[7:5] == 3'b011) begin
            r.extra = box_extra(op[4:2]);
        end else if (op == 8'h80) begin
            r.extra = 4'd3;
        end else if (op >= 8'hA0 && op <= 8'hDF) begin
            r.kind  = K_XFER;
            r.extra = 4'd2;
        end else if (op[7:3] == 5'b11100) begin
            r.kind = K_ENV;
        end
        return r;
    endfunction

endpackage

// File: rtl/cpf_op_decode.sv
module cpf_op_decode
    import cpf_pkg::*;
(
    input  logic [7:0] op,
    output op_info_t   info
);
    always_comb info = classify(op);
endmodule

// File: rtl/cpf_env_bank.sv
module cpf_env_bank #(
    parameter int NREG = 8,
    localparam int SW = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SW-1:0]    sel,
    input  logic [31:0]      data,
    output logic [NREG*32-1:0] regs
);
    logic [31:0] q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                q[g] <= {8'hE0 + 8'(g), 24'h0};
            else if (we && sel == SW'(g))
                q[g] <= data;
        end
        assign regs[g*32 +: 32] = q[g];
    end

    AST_ENV_STORE: assert property (@(posedge clk) disable iff (rst)
        we |=> q[$past(sel)] == $past(data)); // R8

endmodule

// File: rtl/cpf_gather.sv
module cpf_gather
    import cpf_pkg::*;
#(
    parameter int MAX_WORDS = 16,
    localparam int IW = $clog2(MAX_WORDS),
    localparam int LW = $clog2(MAX_WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [31:0]   in_word,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [31:0]   out_word,
    output logic          out_first,
    output logic          out_last,
    output logic [7:0]    out_opcode,
    output logic [LW-1:0] out_len,
    output logic          out_ovf,
    output logic          xfer_valid,
    input  logic          xfer_ready,
    output logic          xfer_read,
    output logic [31:0]   xfer_pos,
    output logic [31:0]   xfer_size,
    output logic          env_we,
    output logic [2:0]    env_sel,
    output logic [31:0]   env_data
);
    state_e        state_q;
    logic [IW-1:0] idx_q, rd_q;
    logic [LW-1:0] len_q;
    logic [7:0]    op_q;
    logic          ovf_q;
    logic [31:0]   words_q [MAX_WORDS];

    logic [7:0] cur_op;
    op_info_t   info;
    logic       is_env, is_term, at_cap, hit, done, take;

    assign cur_op = (idx_q == '0) ? in_word[31:24] : op_q;

    cpf_op_decode u_dec (
        .op   (cur_op),
        .info (info)
    );

    assign is_env  = (info.kind == K_ENV);
    assign is_term = ((in_word & TERM_MASK) == TERM_VAL);
    assign at_cap  = (idx_q == IW'(MAX_WORDS - 1));
    assign take    = (state_q == ST_GATHER) && in_valid;

    always_comb begin
        hit  = 1'b0;
        done = 1'b0;
        case (info.kind)
            K_FIXED:    done = (idx_q == IW'(info.extra));
            K_XFER:     done = (idx_q == IW'(2));
            K_LINE_ALL: begin
                hit  = (idx_q >= IW'(3)) && is_term;
                done = hit || at_cap;
            end
            K_LINE_ALT: begin
                hit  = (idx_q >= IW'(4)) && !idx_q[0] && is_term;
                done = hit || at_cap;
            end
            default: done = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_GATHER;
            idx_q   <= '0;
            rd_q    <= '0;
            len_q   <= '0;
            op_q    <= '0;
            ovf_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_GATHER: begin
                    if (in_valid && !is_env) begin
                        if (idx_q == '0) op_q <= in_word[31:24];
                        if (done) begin
                            len_q   <= LW'(idx_q) + LW'(1);
                            ovf_q   <= at_cap && !hit;
                            rd_q    <= '0;
                            idx_q   <= '0;
                            state_q <= (info.kind == K_XFER) ? ST_XFER : ST_DRAW;
                        end else begin
                            idx_q <= idx_q + IW'(1);
                        end
                    end
                end
                ST_DRAW: begin
                    if (out_ready) begin
                        if (LW'(rd_q) == len_q - LW'(1)) state_q <= ST_GATHER;
                        else                             rd_q    <= rd_q + IW'(1);
                    end
                end
                ST_XFER: begin
                    if (xfer_ready) state_q <= ST_GATHER;
                end
                default: state_q <= ST_GATHER;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (take && !is_env) words_q[idx_q] <= in_word;
    end

    assign in_ready   = (state_q == ST_GATHER);
    assign out_valid  = (state_q == ST_DRAW);
    assign out_word   = words_q[rd_q];
    assign out_first  = (rd_q == '0);
    assign out_last   = (LW'(rd_q) == len_q - LW'(1));
    assign out_opcode = op_q;
    assign out_len    = len_q;
    assign out_ovf    = ovf_q;
    assign xfer_valid = (state_q == ST_XFER);
    assign xfer_read  = (op_q[7:5] == 3'b110);
    assign xfer_pos   = words_q[1];
    assign xfer_size  = words_q[2];
    assign env_we     = take && is_env;
    assign env_sel    = in_word[26:24];
    assign env_data   = in_word;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_word)
            && $stable(out_len) && $stable(out_opcode) && $stable(out_last)); // R11
    AST_FIRST_OPENS: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> out_first); // R11
    AST_XFER_HOLD: assert property (@(posedge clk) disable iff (rst)
        xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_pos)
            && $stable(xfer_size) && $stable(xfer_read)); // R9
    AST_OVF_AT_CAP: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ovf |-> out_len == LW'(MAX_WORDS)); // R7
    AST_ENV_QUIET: assert property (@(posedge clk) disable iff (rst)
        env_we |=> !out_valid && !xfer_valid); // R8

endmodule

// File: rtl/cmd_packet_framer.sv
module cmd_packet_framer
    import cpf_pkg::*;
#(
    parameter int MAX_WORDS = 16,
    localparam int LW = $clog2(MAX_WORDS + 1),
    localparam int NENV = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_word,
    output logic              out_first,
    output logic              out_last,
    output logic [7:0]        out_opcode,
    output logic [LW-1:0]     out_len,
    output logic              out_ovf,
    output logic              xfer_valid,
    input  logic              xfer_ready,
    output logic              xfer_read,
    output logic [31:0]       xfer_pos,
    output logic [31:0]       xfer_size,
    output logic [NENV*32-1:0] env_regs
);
    logic        env_we;
    logic [2:0]  env_sel;
    logic [31:0] env_data;

    cpf_gather #(.MAX_WORDS(MAX_WORDS)) u_gather (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_word    (in_word),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_word   (out_word),
        .out_first  (out_first),
        .out_last   (out_last),
        .out_opcode (out_opcode),
        .out_len    (out_len),
        .out_ovf    (out_ovf),
        .xfer_valid (xfer_valid),
        .xfer_ready (xfer_ready),
        .xfer_read  (xfer_read),
        .xfer_pos   (xfer_pos),
        .xfer_size  (xfer_size),
        .env_we     (env_we),
        .env_sel    (env_sel),
        .env_data   (env_data)
    );

    cpf_env_bank #(.NREG(NENV)) u_env (
        .clk  (clk),
        .rst  (rst),
        .we   (env_we),
        .sel  (env_sel),
        .data (env_data),
        .regs (env_regs)
    );

endmodule

// File: tb/cmd_packet_framer_bench.sv
module cmd_packet_framer_bench;
    localparam int MAXW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        out_valid, out_first, out_last, out_ovf;
    logic        out_ready = 1'b1;
    logic [31:0] out_word;
    logic [7:0]  out_opcode;
    logic [4:0]  out_len;
    logic        xfer_valid, xfer_read;
    logic        xfer_ready = 1'b1;
    logic [31:0] xfer_pos, xfer_size;
    logic [255:0] env_regs;

    cmd_packet_framer #(.MAX_WORDS(MAXW)) u_cmd_packet_framer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
        .out_first(out_first), .out_last(out_last), .out_opcode(out_opcode),
        .out_len(out_len), .out_ovf(out_ovf), .xfer_valid(xfer_valid),
        .xfer_ready(xfer_ready), .xfer_read(xfer_read), .xfer_pos(xfer_pos),
        .xfer_size(xfer_size), .env_regs(env_regs)
    );

    int checks = 0;
    int fails  = 0;

    // logs of what the ports delivered
    logic [31:0] lw   [0:4095];
    logic        lf   [0:4095];
    logic        ll   [0:4095];
    logic [7:0]  lop  [0:4095];
    logic [4:0]  llen [0:4095];
    logic        lovf [0:4095];
    int          ln = 0;
    logic [31:0] xp [0:511];
    logic [31:0] xs [0:511];
    logic        xr [0:511];
    int          xn = 0;

    bit          stall_mode = 1'b0;
    bit          prev_stall = 1'b0;
    logic [31:0] prev_w;
    logic [31:0] env_exp [0:7];

    logic [31:0] ew [0:31];
    int          en;
    logic [7:0]  eop;
    bit          eovf;

    always @(posedge clk) begin
        #2;
        out_ready  = stall_mode ? 1'($urandom_range(0, 1)) : 1'b1;
        xfer_ready = stall_mode ? 1'($urandom_range(0, 1)) : 1'b1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall) begin
                checks++;
                if (!out_valid || out_word != prev_w || in_ready) begin
                    fails++;
                    $display("FAIL R11 stall hold: actual valid=%0b word=%08h in_ready=%0b expected valid=1 word=%08h in_ready=0",
                             out_valid, out_word, in_ready, prev_w);
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_w     = out_word;
            if (out_valid && out_ready && ln < 4096) begin
                lw[ln] = out_word; lf[ln] = out_first; ll[ln] = out_last;
                lop[ln] = out_opcode; llen[ln] = out_len; lovf[ln] = out_ovf;
                ln++;
            end
            if (xfer_valid && xfer_ready && xn < 512) begin
                xp[xn] = xfer_pos; xs[xn] = xfer_size; xr[xn] = xfer_read;
                xn++;
            end
        end
    end

    // expected packet length from opcode ranges
    function automatic int exp_len(input int op);
        if (op == 'h02) return 3;
        if (op >= 'h20 && op <= 'h23) return 4;
        if (op >= 'h24 && op <= 'h27) return 7;
        if (op >= 'h28 && op <= 'h2B) return 5;
        if (op >= 'h2C && op <= 'h2F) return 9;
        if (op >= 'h30 && op <= 'h33) return 6;
        if (op >= 'h34 && op <= 'h37) return 9;
        if (op >= 'h38 && op <= 'h3B) return 8;
        if (op >= 'h3C && op <= 'h3F) return 12;
        if (op >= 'h40 && op <= 'h47) return 3;
        if (op >= 'h50 && op <= 'h57) return 5;
        if (op >= 'h60 && op <= 'h63) return 3;
        if (op >= 'h64 && op <= 'h67) return 4;
        if (op >= 'h68 && op <= 'h6B) return 2;
        if (op >= 'h6C && op <= 'h6F) return 1;
        if (op >= 'h70 && op <= 'h73) return 2;
        if (op >= 'h74 && op <= 'h77) return 3;
        if (op >= 'h78 && op <= 'h7B) return 2;
        if (op >= 'h7C && op <= 'h7F) return 3;
        if (op == 'h80) return 4;
        return 1;
    endfunction

    function automatic logic [31:0] filler(input int op, input int i);
        return 32'hA000_0000 | (32'(op) << 8) | 32'(i);
    endfunction

    task automatic finish_up();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    task automatic send_word(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 1'b0;
        while (!(in_ready && !out_valid && !xfer_valid)) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_draw(input string tag, input int hold_at);
        int  base;
        bit  ok;
        bit  held_bad;
        int  bad_i;
        base     = ln;
        held_bad = 1'b0;
        for (int i = 0; i < en; i++) begin
            if (hold_at > 0 && i == hold_at) begin
                @(negedge clk);
                in_valid = 1'b0;
                for (int k = 0; k < 10; k++) begin
                    @(negedge clk);
                    if (out_valid || xfer_valid) held_bad = 1'b1;
                end
                checks++;
                if (held_bad) begin
                    fails++;
                    $display("FAIL R10 op=%02h: actual early release=1 expected 0", eop);
                end
            end
            send_word(ew[i]);
        end
        go_idle();
        ok    = (ln - base == en);
        bad_i = -1;
        if (ok) begin
            for (int i = 0; i < en; i++) begin
                if (lw[base+i] != ew[i] || lf[base+i] != (i == 0) || ll[base+i] != (i == en-1)
                    || lop[base+i] != eop || llen[base+i] != 5'(en) || lovf[base+i] != eovf) begin
                    if (bad_i < 0) bad_i = i;
                    ok = 1'b0;
                end
            end
        end
        checks++;
        if (!ok) begin
            fails++;
            if (bad_i >= 0)
                $display("FAIL %s op=%02h idx %0d: actual word=%08h len=%0d ovf=%0b expected word=%08h len=%0d ovf=%0b",
                         tag, eop, bad_i, lw[base+bad_i], llen[base+bad_i], lovf[base+bad_i],
                         ew[bad_i], en, eovf);
            else
                $display("FAIL %s op=%02h: actual words=%0d expected words=%0d", tag, eop, ln - base, en);
        end
    endtask

    task automatic check_env(input string tag, input int base_ln);
        bit ok;
        ok = (ln == base_ln);
        for (int k = 0; k < 8; k++)
            if (env_regs[k*32 +: 32] != env_exp[k]) ok = 1'b0;
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s env: actual regs=%064h renderer words=%0d expected reg0=%08h reg7=%08h renderer words=0",
                     tag, env_regs, ln - base_ln, env_exp[0], env_exp[7]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog: actual=hung expected=finished");
        finish_up();
    end

    initial begin
        int b;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        for (int k = 0; k < 8; k++) env_exp[k] = {8'hE0 + 8'(k), 24'h0};
        checks++;
        if (out_valid || xfer_valid || !in_ready) begin
            fails++;
            $display("FAIL R1 reset: actual out_valid=%0b xfer_valid=%0b in_ready=%0b expected 0 0 1",
                     out_valid, xfer_valid, in_ready);
        end
        check_env("R1", ln);

        // sweep every opcode
        for (int op = 0; op < 256; op++) begin
            eop  = 8'(op);
            eovf = 1'b0;
            ew[0] = {8'(op), 24'(op * 3 + 1)};
            if (op >= 'hE0 && op <= 'hE7) begin
                b = ln;
                send_word(ew[0]);
                go_idle();
                env_exp[op & 7] = ew[0];
                check_env("R8", b);
            end else if (op >= 'hA0 && op <= 'hDF) begin
                int xb;
                xb = xn; b = ln;
                send_word(ew[0]);
                send_word(32'h0012_0034 + 32'(op));
                send_word(32'h0040_0020 + 32'(op));
                go_idle();
                checks++;
                if (xn != xb + 1 || ln != b || xr[xb] != (op >= 'hC0)
                    || xp[xb] != 32'h0012_0034 + 32'(op) || xs[xb] != 32'h0040_0020 + 32'(op)) begin
                    fails++;
                    $display("FAIL R9 op=%02h: actual beats=%0d read=%0b pos=%08h size=%08h expected beats=1 read=%0b pos=%08h size=%08h",
                             op, xn - xb, xr[xb], xp[xb], xs[xb], (op >= 'hC0),
                             32'h0012_0034 + 32'(op), 32'h0040_0020 + 32'(op));
                end
            end else if (op >= 'h48 && op <= 'h4F) begin
                en = 4 + (op & 7);
                for (int i = 1; i < en - 1; i++) ew[i] = filler(op, i);
                ew[2] = 32'h5000_5000;          // R5 unchecked index
                ew[en-1] = 32'h5A00_5B00 | 32'(op);
                run_draw("R5", 0);
            end else if (op >= 'h58 && op <= 'h5F) begin
                int t;
                t  = 4 + 2 * (op & 3);
                en = t + 1;
                for (int i = 1; i < en - 1; i++) ew[i] = ((i & 1) != 0) ? 32'h5300_5400 : filler(op, i);
                ew[en-1] = 32'h5000_5000 | 32'(op);
                run_draw("R6", 0);
            end else begin
                en = exp_len(op);
                for (int i = 1; i < en; i++) ew[i] = filler(op, i);
                if (op >= 'h20 && op <= 'h3F) run_draw("R2", 0);
                else if (en > 1)              run_draw("R3", 0);
                else                          run_draw("R4", 0);
            end
        end

        // R7: cap without terminator, all-words polyline
        eop = 8'h4A; eovf = 1'b1; en = MAXW;
        ew[0] = 32'h4A00_0001;
        for (int i = 1; i < en; i++) ew[i] = filler('h4A, i);
        run_draw("R7", 0);
        // R7: terminator exactly at cap index, no overflow
        eop = 8'h48; eovf = 1'b0; en = MAXW;
        ew[0] = 32'h4800_0002;
        for (int i = 1; i < en - 1; i++) ew[i] = filler('h48, i);
        ew[en-1] = 32'h5123_5456;
        run_draw("R7", 0);
        // R7: alternate-word polyline, pattern on odd cap index is data, cap closes
        eop = 8'h5C; eovf = 1'b1; en = MAXW;
        ew[0] = 32'h5C00_0003;
        for (int i = 1; i < en - 1; i++) ew[i] = filler('h5C, i);
        ew[en-1] = 32'h5000_5000;
        run_draw("R7", 0);
        // R4: a fresh one-word packet right after an overflow
        eop = 8'h01; eovf = 1'b0; en = 1; ew[0] = 32'h0100_0777;
        run_draw("R4", 0);

        // R10: long gap inside a packet
        eop = 8'h2C; eovf = 1'b0; en = 9;
        ew[0] = 32'h2C00_0004;
        for (int i = 1; i < en; i++) ew[i] = filler('h2C, i);
        run_draw("R10", 4);

        // R11: random back-pressure on both ports
        stall_mode = 1'b1;
        eop = 8'h3E; eovf = 1'b0; en = 12;
        ew[0] = 32'h3E00_0005;
        for (int i = 1; i < en; i++) ew[i] = filler('h3E, i);
        run_draw("R11", 0);
        eop = 8'h5B; en = 7;
        ew[0] = 32'h5B00_0006;
        for (int i = 1; i < en - 1; i++) ew[i] = filler('h5B, i);
        ew[5] = 32'h5000_5000;
        ew[6] = 32'h5FFF_5FFF;
        run_draw("R11", 0);
        b = xn;
        send_word(32'hC300_0000);
        send_word(32'h0001_0002);
        send_word(32'h0003_0004);
        go_idle();
        stall_mode = 1'b0;
        checks++;
        if (xn != b + 1 || !xr[b] || xp[b] != 32'h0001_0002 || xs[b] != 32'h0003_0004) begin
            fails++;
            $display("FAIL R9 stalled header: actual beats=%0d pos=%08h size=%08h expected beats=1 pos=00010002 size=00030004",
                     xn - b, xp[b], xs[b]);
        end

        finish_up();
    end

endmodule